// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries short messages between two ports that run on unrelated clocks, alongside a FIFO path that is not part of it. Port A posts words into mailbox 1, and port B collects them. Port B posts words into mailbox 2, and port A collects them. Each mailbox keeps one word. Each mailbox also has an active-low flag that the writing port sees. The flag goes low when a message is posted. It goes high again once the other side has collected the message.

Each port has an active-low chip select, a direction select, an enable and a mailbox select. The direction select has opposite meanings on the two ports. On port A, high means write. On port B, high means read. The block decodes these four inputs into accepted writes, accepted reads and a data output enable. The output enable stands in for a tri-state pad. Port B drives either mailbox 1 or a FIFO output word that is supplied from outside.

Handshakes between the domains use toggle signals. Each toggle passes through a two-flop synchronizer, so the flag updates a few clocks after the event on the other side. A read counts only when the reader's domain has already seen the posted message. Because of this, an early or empty read can never release a message that has not yet been collected.

Top module: `dual_clk_mailbox`

## Requirements
- R1: While `rstN` is low, and after reset is released, both `mbx1FlagN` and `mbx2FlagN` are 1 and both mailboxes hold 0.
- R2: A rising `clkA` edge with `aSelN`=0, `aWrRd`=1, `aEn`=1, `aMbx`=1 while `mbx1FlagN`=1 stores `aDataIn` in mailbox 1. `mbx1FlagN` reads 0 right after that edge.
- R3: A rising `clkB` edge with `bSelN`=0, `bWrRd`=0, `bEn`=1, `bMbx`=1 while `mbx2FlagN`=1 stores `bDataIn` in mailbox 2. `mbx2FlagN` reads 0 right after that edge.
- R4: A mailbox write that arrives while that mailbox's flag is 0 is dropped, and the stored word is kept.
- R5: A read of mailbox 1 is a `clkB` edge with `bSelN`=0, `bWrRd`=1, `bEn`=1, `bMbx`=1. Once the read is three or more `clkB` edges after the write, it releases the message. `mbx1FlagN` then returns to 1 on the 2nd or 3rd `clkA` edge after the read, and it rises only once per message.
- R6: A read of mailbox 2 is a `clkA` edge with `aSelN`=0, `aWrRd`=0, `aEn`=1, `aMbx`=1. Once the read is three or more `clkA` edges after the write, it releases the message. `mbx2FlagN` then returns to 1 on the 2nd or 3rd `clkB` edge after the read, and it rises only once per message.
- R7: A read of a mailbox that holds no message has no effect. A message posted later keeps its flag at 0 until a real read.
- R8: `aDataOe` is 1 exactly when `aSelN`=0 and `aWrRd`=0. `aDataOut` then shows mailbox 2; otherwise it is 0.
- R9: `bDataOe` is 1 exactly when `bSelN`=0 and `bWrRd`=1. `bDataOut` then shows mailbox 1 when `bMbx`=1 and `fifoWord` when `bMbx`=0; otherwise it is 0.
- R10: With the enable at 0, or the mailbox select at 0 (FIFO access), no mailbox is written or read and both flags stay unchanged.
- R11: A write request held on port A while mailbox 1 is occupied is accepted exactly once. It is taken at the first `clkA` edge after `mbx1FlagN` returns to 1, and it stores the data present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock, unrelated to clkA |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| aSelN | input | 1 | Port A chip select, active low |
| aWrRd | input | 1 | Port A direction: 1 write, 0 read |
| aEn | input | 1 | Port A enable |
| aMbx | input | 1 | Port A mailbox select: 1 mailbox, 0 FIFO |
| aDataIn | input | WIDTH | Port A write data |
| aDataOut | output | WIDTH | Port A read data (mailbox 2) |
| aDataOe | output | 1 | Port A output enable |
| bSelN | input | 1 | Port B chip select, active low |
| bWrRd | input | 1 | Port B direction: 1 read, 0 write |
| bEn | input | 1 | Port B enable |
| bMbx | input | 1 | Port B mailbox select: 1 mailbox, 0 FIFO |
| bDataIn | input | WIDTH | Port B write data |
| fifoWord | input | WIDTH | FIFO output register word shown on port B |
| bDataOut | output | WIDTH | Port B read data |
| bDataOe | output | 1 | Port B output enable |
| mbx1FlagN | output | 1 | 0 while mailbox 1 holds an uncollected message (clkA domain) |
| mbx2FlagN | output | 1 | 0 while mailbox 2 holds an uncollected message (clkB domain) |

## Verification
Two events can meet on the same `clkA` edge. One is the release of mailbox 1 arriving back from port B. The other is a new port-A write to mailbox 1. To provoke this, the bench holds a port-A write request asserted on every edge and changes its data each cycle, while port B collects the previous message. The bench judges the result in three ways. The flag must be seen high for exactly one `clkA` cycle. The word that port B reads next must equal the data driven at the edge after that cycle. Every earlier write attempt during the occupied period must be dropped.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic loadMb1;   // accepted port-A write into mailbox 1 (clkA domain)
    logic loadMb2;   // accepted port-B write into mailbox 2 (clkB domain)
    logic aOe;       // port A drives its data pins
    logic bOe;       // port B drives its data pins
    logic bPickMb;   // port B shows mailbox 1 instead of the FIFO word
  } mbxStrobes_t;

  localparam int unsigned MBX_COUNT = 2;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_chan.sv
// One mailbox handshake: writer toggle and reader toggle, each seen in the
// other domain through a synchronizer.
module mbx_chan #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic wClk,
  input  logic rClk,
  input  logic rstN,
  input  logic wReq,
  input  logic rReq,
  output logic wAccept,
  output logic rAccept,
  output logic flagN
);
  logic wTgl, rTgl;
  logic rTglAtW, wTglAtR;
  logic holding, pending;

  mbx_sync #(.STAGES(SYNC_STAGES)) syncToW_i (
    .clk(wClk), .rstN(rstN), .d(rTgl), .q(rTglAtW)
  );
  mbx_sync #(.STAGES(SYNC_STAGES)) syncToR_i (
    .clk(rClk), .rstN(rstN), .d(wTgl), .q(wTglAtR)
  );

  // writer side: occupied until the reader's toggle catches up
  assign holding = wTgl ^ rTglAtW;
  assign flagN   = ~holding;
  assign wAccept = wReq & ~holding;

  // reader side: a message is visible once the writer's toggle arrives
  assign pending = wTglAtR ^ rTgl;
  assign rAccept = rReq & pending;

  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN)        wTgl <= 1'b0;
    else if (wAccept) wTgl <= ~wTgl;
  end

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN)        rTgl <= 1'b0;
    else if (rAccept) rTgl <= ~rTgl;
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clkA,
  input  logic        clkB,
  input  logic        rstN,
  input  logic        aSelN,
  input  logic        aWrRd,
  input  logic        aEn,
  input  logic        aMbx,
  input  logic        bSelN,
  input  logic        bWrRd,
  input  logic        bEn,
  input  logic        bMbx,
  output mbxStrobes_t strobes,
  output logic [MBX_COUNT-1:0] flagsN
);
  logic aAct, bAct;
  logic [MBX_COUNT-1:0] clkVec;
  logic [MBX_COUNT-1:0] wReq, rReq, wAccept, rAccept;

  assign aAct = ~aSelN & aEn & aMbx;
  assign bAct = ~bSelN & bEn & bMbx;

  // index 0: mailbox 1 (A writes, B reads); index 1: mailbox 2 (B writes, A reads)
  assign clkVec = {clkB, clkA};
  assign wReq   = {bAct & ~bWrRd, aAct & aWrRd};
  assign rReq   = {aAct & ~aWrRd, bAct & bWrRd};

  for (genvar i = 0; i < MBX_COUNT; i++) begin : g_chan
    mbx_chan #(.SYNC_STAGES(SYNC_STAGES)) chan_i (
      .wClk   (clkVec[i]),
      .rClk   (clkVec[MBX_COUNT-1-i]),
      .rstN   (rstN),
      .wReq   (wReq[i]),
      .rReq   (rReq[i]),
      .wAccept(wAccept[i]),
      .rAccept(rAccept[i]),
      .flagN  (flagsN[i])
    );
  end

  always_comb begin
    strobes.loadMb1 = wAccept[0];
    strobes.loadMb2 = wAccept[1];
    strobes.aOe     = ~aSelN & ~aWrRd;
    strobes.bOe     = ~bSelN & bWrRd;
    strobes.bPickMb = bMbx;
  end

  logic unusedReads;
  assign unusedReads = ^rAccept;
endmodule

// File: rtl/mbx_data.sv
module mbx_data
  import mbx_pkg::*;
#(
  parameter int unsigned WIDTH = 36
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  mbxStrobes_t      strobes,
  input  logic [WIDTH-1:0] aDataIn,
  input  logic [WIDTH-1:0] bDataIn,
  input  logic [WIDTH-1:0] fifoWord,
  output logic [WIDTH-1:0] aDataOut,
  output logic [WIDTH-1:0] bDataOut
);
  logic [WIDTH-1:0] mb1Q, mb2Q;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)                mb1Q <= '0;
    else if (strobes.loadMb1) mb1Q <= aDataIn;
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)                mb2Q <= '0;
    else if (strobes.loadMb2) mb2Q <= bDataIn;
  end

  always_comb begin
    aDataOut = strobes.aOe ? mb2Q : '0;
    if (!strobes.bOe)          bDataOut = '0;
    else if (strobes.bPickMb)  bDataOut = mb1Q;
    else                       bDataOut = fifoWord;
  end
endmodule

// File: rtl/dual_clk_mailbox.sv
module dual_clk_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned WIDTH       = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  logic             aSelN,
  input  logic             aWrRd,
  input  logic             aEn,
  input  logic             aMbx,
  input  logic [WIDTH-1:0] aDataIn,
  output logic [WIDTH-1:0] aDataOut,
  output logic             aDataOe,
  input  logic             bSelN,
  input  logic             bWrRd,
  input  logic             bEn,
  input  logic             bMbx,
  input  logic [WIDTH-1:0] bDataIn,
  input  logic [WIDTH-1:0] fifoWord,
  output logic [WIDTH-1:0] bDataOut,
  output logic             bDataOe,
  output logic             mbx1FlagN,
  output logic             mbx2FlagN
);
  mbxStrobes_t strobes;
  logic [MBX_COUNT-1:0] flagsN;

  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aSelN(aSelN), .aWrRd(aWrRd), .aEn(aEn), .aMbx(aMbx),
    .bSelN(bSelN), .bWrRd(bWrRd), .bEn(bEn), .bMbx(bMbx),
    .strobes(strobes), .flagsN(flagsN)
  );

  mbx_data #(.WIDTH(WIDTH)) data_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .strobes(strobes),
    .aDataIn(aDataIn), .bDataIn(bDataIn), .fifoWord(fifoWord),
    .aDataOut(aDataOut), .bDataOut(bDataOut)
  );

  assign aDataOe   = strobes.aOe;
  assign bDataOe   = strobes.bOe;
  assign mbx1FlagN = flagsN[0];
  assign mbx2FlagN = flagsN[1];
endmodule

// File: rtl/dual_clk_mailbox_chk.sv
module dual_clk_mailbox_chk #(
  parameter int unsigned WIDTH = 36
) (
  input logic             clkA,
  input logic             clkB,
  input logic             rstN,
  input logic             aSelN,
  input logic             aWrRd,
  input logic             aEn,
  input logic             aMbx,
  input logic [WIDTH-1:0] aDataOut,
  input logic             aDataOe,
  input logic             bSelN,
  input logic             bWrRd,
  input logic             bEn,
  input logic             bMbx,
  input logic [WIDTH-1:0] fifoWord,
  input logic [WIDTH-1:0] bDataOut,
  input logic             bDataOe,
  input logic             mbx1FlagN,
  input logic             mbx2FlagN
);
  // R1: reset holds both flags high
  always_comb begin
    if (!rstN) begin
      p_reset_flags_r1: assert (mbx1FlagN && mbx2FlagN);
    end
  end

  // R2: an accepted port-A write occupies mailbox 1 at once
  p_mb1_occupy_r2: assert property (@(posedge clkA) disable iff (!rstN)
    (!aSelN && aWrRd && aEn && aMbx && mbx1FlagN) |=> !mbx1FlagN);

  // R3: an accepted port-B write occupies mailbox 2 at once
  p_mb2_occupy_r3: assert property (@(posedge clkB) disable iff (!rstN)
    (!bSelN && !bWrRd && bEn && bMbx && mbx2FlagN) |=> !mbx2FlagN);

  // R8: port A is quiet while not driving
  p_a_quiet_r8: assert property (@(posedge clkA) disable iff (!rstN)
    !aDataOe |-> (aDataOut == '0));

  // R9: port B is quiet while not driving, and passes the FIFO word otherwise
  p_b_quiet_r9: assert property (@(posedge clkB) disable iff (!rstN)
    !bDataOe |-> (bDataOut == '0));
  p_b_fifo_r9: assert property (@(posedge clkB) disable iff (!rstN)
    (bDataOe && !bMbx) |-> (bDataOut == fifoWord));
endmodule

bind dual_clk_mailbox dual_clk_mailbox_chk #(.WIDTH(WIDTH)) chk_i (
  .clkA(clkA), .clkB(clkB), .rstN(rstN),
  .aSelN(aSelN), .aWrRd(aWrRd), .aEn(aEn), .aMbx(aMbx),
  .aDataOut(aDataOut), .aDataOe(aDataOe),
  .bSelN(bSelN), .bWrRd(bWrRd), .bEn(bEn), .bMbx(bMbx),
  .fifoWord(fifoWord), .bDataOut(bDataOut), .bDataOe(bDataOe),
  .mbx1FlagN(mbx1FlagN), .mbx2FlagN(mbx2FlagN)
);

// File: tb/dual_clk_mailbox_tb_top.sv
`timescale 1ns/10ps
module dual_clk_mailbox_tb_top;
  localparam int W = 36;

  logic clkA = 0, clkB = 0, rstN = 0;
  logic aSelN = 1, aWrRd = 0, aEn = 0, aMbx = 0;
  logic bSelN = 1, bWrRd = 0, bEn = 0, bMbx = 0;
  logic [W-1:0] aDataIn = '0, bDataIn = '0, fifoWord = '0;
  logic [W-1:0] aDataOut, bDataOut;
  logic aDataOe, bDataOe, mbx1FlagN, mbx2FlagN;

  int tests = 0, fails = 0;
  int aEdges = 0, bEdges = 0;
  bit done = 0;
  logic [W-1:0] curMb1 = '0, curMb2 = '0;

  dual_clk_mailbox #(.WIDTH(W)) dut_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aSelN(aSelN), .aWrRd(aWrRd), .aEn(aEn), .aMbx(aMbx),
    .aDataIn(aDataIn), .aDataOut(aDataOut), .aDataOe(aDataOe),
    .bSelN(bSelN), .bWrRd(bWrRd), .bEn(bEn), .bMbx(bMbx),
    .bDataIn(bDataIn), .fifoWord(fifoWord), .bDataOut(bDataOut),
    .bDataOe(bDataOe), .mbx1FlagN(mbx1FlagN), .mbx2FlagN(mbx2FlagN)
  );

  // 125 MHz on port A; port B unrelated, phase chosen so edges never coincide
  initial forever #4 clkA = ~clkA;
  initial begin #0.37; forever #5.85 clkB = ~clkB; end

  always @(posedge clkA) aEdges <= aEdges + 1;
  always @(posedge clkB) bEdges <= bEdges + 1;

  function automatic logic [W-1:0] pat(input int k);
    return W'(k) * 36'h9_E377_9B97 + 36'h1_0000_0003;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic aIdle();
    aSelN = 1; aWrRd = 0; aEn = 0; aMbx = 0;
  endtask
  task automatic bIdle();
    bSelN = 1; bWrRd = 0; bEn = 0; bMbx = 0;
  endtask

  task automatic aWriteMb1(input logic [W-1:0] d, input string tag);
    @(negedge clkA); aSelN = 0; aWrRd = 1; aEn = 1; aMbx = 1; aDataIn = d;
    @(posedge clkA); #1;
    check(mbx1FlagN == 0, tag, 64'(mbx1FlagN), 0);
    @(negedge clkA); aIdle();
  endtask

  task automatic bWriteMb2(input logic [W-1:0] d, input string tag);
    @(negedge clkB); bSelN = 0; bWrRd = 0; bEn = 1; bMbx = 1; bDataIn = d;
    @(posedge clkB); #1;
    check(mbx2FlagN == 0, tag, 64'(mbx2FlagN), 0);
    @(negedge clkB); bIdle();
  endtask

  // R5: collect mailbox 1 on port B, time the release in clkA edges
  task automatic bReadMb1(input logic [W-1:0] exp);
    int snap, n;
    repeat (3) @(negedge clkB);
    bSelN = 0; bWrRd = 1; bMbx = 1; bEn = 1; #1;
    check(bDataOe && bDataOut == exp, "R5/R9 mailbox 1 data on port B", bDataOut, exp);
    @(posedge clkB); snap = aEdges;
    @(negedge clkB);               // one more enabled edge: must be ignored
    @(negedge clkB); bIdle();
    for (int i = 0; i < 20 && !mbx1FlagN; i++) @(negedge clkA);
    n = aEdges - snap;
    check(mbx1FlagN && n >= 2 && n <= 3, "R5 mbx1 release latency", 64'(n), 2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clkA);
      check(mbx1FlagN == 1, "R5 mbx1 rises once", 64'(mbx1FlagN), 1);
    end
  endtask

  // R6: collect mailbox 2 on port A, time the release in clkB edges
  task automatic aReadMb2(input logic [W-1:0] exp);
    int snap, n;
    repeat (3) @(negedge clkA);
    aSelN = 0; aWrRd = 0; aMbx = 1; aEn = 1; #1;
    check(aDataOe && aDataOut == exp, "R6/R8 mailbox 2 data on port A", aDataOut, exp);
    @(posedge clkA); snap = bEdges;
    @(negedge clkA);
    @(negedge clkA); aIdle();
    for (int i = 0; i < 20 && !mbx2FlagN; i++) @(negedge clkB);
    n = bEdges - snap;
    check(mbx2FlagN && n >= 2 && n <= 3, "R6 mbx2 release latency", 64'(n), 2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clkB);
      check(mbx2FlagN == 1, "R6 mbx2 rises once", 64'(mbx2FlagN), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clkA);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clkA);
    check(mbx1FlagN && mbx2FlagN, "R1 flags in reset", {mbx1FlagN, mbx2FlagN}, 2'b11);
    check(!aDataOe && !bDataOe && aDataOut == 0 && bDataOut == 0,
          "R1 outputs idle in reset", aDataOut | bDataOut, 0);
    rstN = 1;
    repeat (4) @(negedge clkA);
    check(mbx1FlagN && mbx2FlagN, "R1 flags after reset", {mbx1FlagN, mbx2FlagN}, 2'b11);

    // R8/R10/R7: every port-A control combination except the mailbox write
    for (int c = 0; c < 16; c++) begin
      logic oe;
      logic [W-1:0] expOut;
      if (c == 4'b0111) continue;
      @(negedge clkA);
      {aSelN, aWrRd, aEn, aMbx} = 4'(c);
      #1;
      oe = !aSelN && !aWrRd;
      expOut = oe ? curMb2 : '0;
      check(aDataOe == oe, "R8 port A output enable", 64'(aDataOe), 64'(oe));
      check(aDataOut == expOut, "R8 port A data", aDataOut, expOut);
      @(negedge clkA); aIdle();
      repeat (4) @(negedge clkA);
      check(mbx1FlagN && mbx2FlagN, "R10/R7 port A combo leaves flags",
            {mbx1FlagN, mbx2FlagN}, 2'b11);
    end

    // R9/R10/R7: every port-B control combination except the mailbox write
    fifoWord = 36'hA_5A5A_C3C3;
    for (int c = 0; c < 16; c++) begin
      logic oe;
      logic [W-1:0] expOut;
      if (c == 4'b0011) continue;
      @(negedge clkB);
      {bSelN, bWrRd, bEn, bMbx} = 4'(c);
      #1;
      oe = !bSelN && bWrRd;
      expOut = !oe ? '0 : (bMbx ? curMb1 : fifoWord);
      check(bDataOe == oe, "R9 port B output enable", 64'(bDataOe), 64'(oe));
      check(bDataOut == expOut, "R9 port B data", bDataOut, expOut);
      @(negedge clkB); bIdle();
      repeat (4) @(negedge clkB);
      check(mbx1FlagN && mbx2FlagN, "R10/R7 port B combo leaves flags",
            {mbx1FlagN, mbx2FlagN}, 2'b11);
    end

    // R2/R3/R5/R6: round trips with distinct patterns both ways
    for (int k = 0; k < 4; k++) begin
      aWriteMb1(pat(k), "R2 mbx1 low after write");
      curMb1 = pat(k);
      bReadMb1(curMb1);
      bWriteMb2(pat(k + 10), "R3 mbx2 low after write");
      curMb2 = pat(k + 10);
      aReadMb2(curMb2);
    end

    // R4: a second write while occupied is dropped
    aWriteMb1(pat(20), "R2 mbx1 low after write");
    curMb1 = pat(20);
    aWriteMb1(pat(21), "R4 mbx1 stays low on dropped write");
    bReadMb1(curMb1);
    bWriteMb2(pat(22), "R3 mbx2 low after write");
    curMb2 = pat(22);
    bWriteMb2(pat(23), "R4 mbx2 stays low on dropped write");
    aReadMb2(curMb2);

    // R7: an empty read must not release a later message
    @(negedge clkB); bSelN = 0; bWrRd = 1; bMbx = 1; bEn = 1;
    @(negedge clkB); bIdle();
    aWriteMb1(pat(30), "R2 mbx1 low after write");
    curMb1 = pat(30);
    repeat (12) @(negedge clkA);
    check(mbx1FlagN == 0, "R7 empty read did not release", 64'(mbx1FlagN), 0);
    bReadMb1(curMb1);

    // R11: held write request meets the release on port A
    aWriteMb1(pat(40), "R2 mbx1 low after write");
    curMb1 = pat(40);
    begin
      int highSeen = 0;
      logic [W-1:0] captured = '0;
      fork
        begin
          for (int i = 0; i < 30; i++) begin
            @(negedge clkA);
            if (mbx1FlagN) begin highSeen++; captured = pat(100 + i); end
            aSelN = 0; aWrRd = 1; aEn = 1; aMbx = 1; aDataIn = pat(100 + i);
          end
          @(negedge clkA); aIdle();
        end
        begin
          repeat (3) @(negedge clkB);
          bSelN = 0; bWrRd = 1; bMbx = 1; bEn = 1; #1;
          check(bDataOut == curMb1, "R5 data before held write", bDataOut, curMb1);
          @(negedge clkB); bIdle();
        end
      join
      check(highSeen == 1, "R11 free for exactly one cycle", 64'(highSeen), 1);
      check(mbx1FlagN == 0, "R11 held write accepted", 64'(mbx1FlagN), 0);
      curMb1 = captured;
      bReadMb1(curMb1);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule